// File: doc/BRIEF.md
# Max-min fair rate allocator

This block divides one shared capacity among up to N requesters so that the allocation is max-min fair. Every requester whose demand fits under the common level receives its full demand. The requesters that cannot be fully served all receive the same level, which is set as high as the capacity permits. The values are unsigned fixed point with `FRAC` fraction bits. The arithmetic treats them as raw integers, so the binary point only affects how the caller reads them.

A job is loaded over a valid/ready handshake. `start_ready` is high only while the engine is idle. A job transfers on a rising clock edge where both `start_valid` and `start_ready` are high, and it carries the whole demand vector and the capacity in parallel. Holding `start_valid` high while `start_ready` is low has no effect, and the caller may keep its inputs up until `start_ready` returns.

The engine works in rounds, one per clock. In each round it divides the remaining pool by the number of requesters still open, truncating the result. It serves in full every open requester whose demand is at or below that share, and it returns their demands to the pool. When a round serves nobody new, every remaining requester receives the share. The job also ends when a round closes all the remaining requesters. The result side has no back-pressure: `done` pulses for one cycle, and `alloc_flat` keeps the result until the next job is accepted.

Top module: `mmf_alloc_top`

## Requirements
- R1: `start_ready` is 1 when idle and 0 from the cycle after a job is accepted until its `done` pulse. A `start_valid` seen while `start_ready` is 0 loads nothing, and the running job's result is unaffected.
- R2: No allocation exceeds its requester's demand.
- R3: All requesters that receive less than their demand receive the same value.
- R4: Small demands are served first: every requester whose demand is at or below the common level of the unmet requesters receives its full demand.
- R5: Raw demands 20, 26, 40 and 50 with raw capacity 100 give raw allocations 20, 26, 27 and 27.
- R6: Each share is floor(pool / open count) in raw LSBs. The residue of the division stays unallocated, so the allocations sum to at most the capacity. For example, four demands of 10 with capacity 7 give 1 each.
- R7: The engine uses one round per cycle. It finishes in the first round that either serves no new requester or serves every open one. `done` rises k cycles after the accepting edge, where k is the round count and k ≤ N.
- R8: A zero demand counts as served from the start and receives 0. If all demands are zero, the job ends after one round.
- R9: If all demands fit within the capacity, each allocation equals its demand.
- R10: `done` is high for exactly one cycle. `alloc_flat` holds its value until the next job is accepted.
- R11: After reset, `start_ready` = 1, `done` = 0 and all allocations are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | Job offered |
| start_ready | output | 1 | Engine idle, job can be taken |
| demand_flat | input | N*W | Demands; requester i at bits [i*W +: W] |
| capacity | input | W | Capacity to divide |
| done | output | 1 | One-cycle pulse, result final |
| alloc_flat | output | N*W | Allocations; requester i at bits [i*W +: W] |

## Verification
The delay of `done` depends on the data, so the bench's reference model computes both the allocations and the round count k for each job. Each job is checked for `done` exactly k cycles after the accepting edge, and never more than N. The bench counts cycles from the accepting edge and samples on falling edges. It reads `start_ready` one cycle after acceptance, reads the allocations in the `done` cycle, and confirms that `done` is low in the next cycle. It checks that the allocations are held several idle cycles later, after the inputs have been scrambled.

// File: rtl/mmf_pkg.sv
package mmf_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} mmf_state_e;

  function automatic int cnt_width(input int n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/mmf_popcnt.sv
module mmf_popcnt #(
  parameter int N  = 4,
  parameter int CW = 3
) (
  input  logic [N-1:0]  bits,
  output logic [CW-1:0] count
);
  always_comb begin
    count = '0;
    for (int i = 0; i < N; i++) begin
      count = count + {{(CW-1){1'b0}}, bits[i]};
    end
  end
endmodule

// File: rtl/mmf_round.sv
module mmf_round #(
  parameter int N  = 4,
  parameter int W  = 16,
  parameter int CW = 3
) (
  input  logic [W-1:0]   rem,
  input  logic [N-1:0]   open,
  input  logic [N*W-1:0] dmd,
  output logic [W-1:0]   share,
  output logic [N-1:0]   newly,
  output logic [W-1:0]   take,
  output logic [CW-1:0]  n_open,
  output logic [CW-1:0]  n_new
);
  mmf_popcnt #(.N(N), .CW(CW)) u_cnt_open (.bits(open),  .count(n_open));
  mmf_popcnt #(.N(N), .CW(CW)) u_cnt_new  (.bits(newly), .count(n_new));

  // truncating share of the pool per open requester
  always_comb begin
    if (n_open == '0) share = '0;
    else              share = rem / {{(W-CW){1'b0}}, n_open};
  end

  for (genvar i = 0; i < N; i++) begin : g_lane
    assign newly[i] = open[i] && (dmd[i*W +: W] <= share);
  end

  // newly served demands never exceed the pool, so W bits suffice
  always_comb begin
    take = '0;
    for (int i = 0; i < N; i++) begin
      if (newly[i]) take = take + dmd[i*W +: W];
    end
  end
endmodule

// File: rtl/mmf_alloc_top.sv
module mmf_alloc_top #(
  parameter int N    = 4,
  parameter int W    = 16,
  parameter int FRAC = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_valid,
  output logic           start_ready,
  input  logic [N*W-1:0] demand_flat,
  input  logic [W-1:0]   capacity,
  output logic           done,
  output logic [N*W-1:0] alloc_flat
);
  import mmf_pkg::*;
  localparam int CW = cnt_width(N);

  if (FRAC > W || CW >= W) begin : g_bad_cfg
    $error("mmf_alloc_top: FRAC or N does not fit in W");
  end

  mmf_state_e     st_q;
  logic           done_q;
  logic [W-1:0]   rem_q;
  logic [N-1:0]   open_q;
  logic [N*W-1:0] dmd_q;
  logic [N*W-1:0] alloc_q;

  logic [W-1:0]  share, take;
  logic [N-1:0]  newly;
  logic [CW-1:0] n_open, n_new;
  logic          accept, last_rnd;

  assign start_ready = (st_q == ST_IDLE);
  assign done        = done_q;
  assign alloc_flat  = alloc_q;
  assign accept      = start_valid && start_ready;

  mmf_round #(.N(N), .W(W), .CW(CW)) u_round (
    .rem(rem_q), .open(open_q), .dmd(dmd_q),
    .share(share), .newly(newly), .take(take),
    .n_open(n_open), .n_new(n_new)
  );

  assign last_rnd = (n_new == '0) || (n_new == n_open);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      done_q  <= 1'b0;
      rem_q   <= '0;
      open_q  <= '0;
      dmd_q   <= '0;
      alloc_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        st_q    <= ST_RUN;
        rem_q   <= capacity;
        dmd_q   <= demand_flat;
        alloc_q <= '0;
        for (int i = 0; i < N; i++) begin
          open_q[i] <= (demand_flat[i*W +: W] != '0);
        end
      end else if (st_q == ST_RUN) begin
        rem_q  <= rem_q - take;
        open_q <= open_q & ~newly;
        for (int i = 0; i < N; i++) begin
          if (newly[i])                  alloc_q[i*W +: W] <= dmd_q[i*W +: W];
          else if (last_rnd && open_q[i]) alloc_q[i*W +: W] <= share;
        end
        if (last_rnd) begin
          st_q   <= ST_IDLE;
          done_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mmf_alloc_chk.sv
module mmf_alloc_chk #(
  parameter int N = 4,
  parameter int W = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start_valid,
  input logic           start_ready,
  input logic [N*W-1:0] demand_flat,
  input logic [W-1:0]   capacity,
  input logic           done,
  input logic [N*W-1:0] alloc_flat
);
  localparam int SW = W + $clog2(N + 1);

  logic [N*W-1:0] d_l;
  logic [W-1:0]   c_l;
  int unsigned    rc;
  logic [SW-1:0]  sum;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      d_l <= '0; c_l <= '0; rc <= 0;
    end else if (start_valid && start_ready) begin
      d_l <= demand_flat; c_l <= capacity; rc <= 0;
    end else if (!start_ready) begin
      rc <= rc + 1;
    end
  end

  always_comb begin
    sum = '0;
    for (int i = 0; i < N; i++) sum = sum + SW'(alloc_flat[i*W +: W]);
  end

  assert_busy_after_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start_valid && start_ready) |=> !start_ready);
  assert_idle_at_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> start_ready);
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ready && !start_valid) |=> $stable(alloc_flat));
  assert_rounds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !start_ready |-> (rc < N));
  assert_sum_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (sum <= SW'(c_l)));

  for (genvar i = 0; i < N; i++) begin : g_i
    assert_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (alloc_flat[i*W +: W] <= d_l[i*W +: W]));
    for (genvar j = 0; j < N; j++) begin : g_j
      if (i < j) begin : g_eq
        assert_equal_R3: assert property (@(posedge clk) disable iff (!rst_n)
          (done && alloc_flat[i*W +: W] < d_l[i*W +: W] && alloc_flat[j*W +: W] < d_l[j*W +: W])
          |-> (alloc_flat[i*W +: W] == alloc_flat[j*W +: W]));
      end
      if (i != j) begin : g_ord
        assert_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
          (done && alloc_flat[i*W +: W] < d_l[i*W +: W] && d_l[j*W +: W] <= alloc_flat[i*W +: W])
          |-> (alloc_flat[j*W +: W] == d_l[j*W +: W]));
      end
    end
  end
endmodule

bind mmf_alloc_top mmf_alloc_chk #(.N(N), .W(W)) u_chk (.*);

// File: tb/sim_mmf_alloc_top.sv
`timescale 1ns/1ps
module sim_mmf_alloc_top;
  localparam int N = 4;
  localparam int W = 16;

  logic clk = 0;
  logic rst_n = 0;
  logic start_valid = 0;
  logic start_ready, done;
  logic [N*W-1:0] demand_flat = '0;
  logic [W-1:0] capacity = '0;
  logic [N*W-1:0] alloc_flat;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  int unsigned dv[N];
  int unsigned cv;
  int unsigned ev[N];
  int er;

  always #2.5 clk = ~clk;

  mmf_alloc_top #(.N(N), .W(W), .FRAC(4)) u0 (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
    .demand_flat(demand_flat), .capacity(capacity), .done(done), .alloc_flat(alloc_flat)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference water-filling model
  task automatic model();
    int unsigned rem = cv;
    bit open[N];
    int cnt, nn;
    int unsigned share;
    er = 0;
    for (int i = 0; i < N; i++) begin open[i] = (dv[i] != 0); ev[i] = 0; end
    forever begin
      er++;
      cnt = 0;
      for (int i = 0; i < N; i++) if (open[i]) cnt++;
      share = (cnt == 0) ? 0 : rem / cnt;
      nn = 0;
      for (int i = 0; i < N; i++)
        if (open[i] && dv[i] <= share) begin
          ev[i] = dv[i]; open[i] = 0; rem -= dv[i]; nn++;
        end
      if (nn == 0 || nn == cnt) begin
        for (int i = 0; i < N; i++) if (open[i]) ev[i] = share;
        break;
      end
    end
  endtask

  task automatic run_job(input string tag, input bit poke);
    int cyc = 0;
    model();
    @(negedge clk);
    for (int i = 0; i < N; i++) demand_flat[i*W +: W] = W'(dv[i]);
    capacity = W'(cv);
    start_valid = 1;
    chk("R1 ready when idle", start_ready, 1);
    @(posedge clk);
    @(negedge clk);
    start_valid = 0;
    chk("R1 busy after accept", start_ready, 0);
    if (poke) begin
      start_valid = 1;
      demand_flat = {N{W'(1)}};
      capacity = W'(9999);
    end
    while (!done && cyc < 40) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      start_valid = 0;
    end
    chk({"R7 round count ", tag}, cyc, er);
    checks++;
    if (cyc > N) begin failures++; $display("FAIL R7 rounds actual=%0d expected<=%0d", cyc, N); end
    for (int i = 0; i < N; i++)
      chk({"R2/R3/R4 alloc ", tag}, alloc_flat[i*W +: W], ev[i]);
    @(negedge clk);
    chk("R10 done pulse", done, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R11 ready after reset", start_ready, 1);
    chk("R11 done after reset", done, 0);
    chk("R11 alloc after reset", alloc_flat, 0);
    rst_n = 1;

    dv = '{20, 26, 40, 50}; cv = 100;
    run_job("R5", 0);
    chk("R5 a2", alloc_flat[2*W +: W], 27);
    chk("R5 a3", alloc_flat[3*W +: W], 27);

    dv = '{3, 7, 1, 2}; cv = 100;
    run_job("R9", 0);
    for (int i = 0; i < N; i++) chk("R9 equals demand", alloc_flat[i*W +: W], dv[i]);

    dv = '{0, 0, 0, 0}; cv = 50;
    run_job("R8 all zero", 0);
    chk("R8 one round", er, 1);

    dv = '{0, 5, 9, 100}; cv = 30;
    run_job("R8 one zero", 0);
    chk("R8 zero gets zero", alloc_flat[0 +: W], 0);
    chk("R4 big gets rest", alloc_flat[3*W +: W], 16);

    dv = '{10, 10, 10, 10}; cv = 7;
    run_job("R6 truncation", 0);
    chk("R6 floor share", alloc_flat[0 +: W], 1);

    dv = '{10, 30, 60, 500}; cv = 160;
    run_job("R1 ignore while busy", 1);
    chk("R1 poke ignored a3", alloc_flat[3*W +: W], 60);
    chk("R1 idle after poke", start_ready, 1);

    // hold: scramble inputs without start_valid
    demand_flat = '1; capacity = '1;
    repeat (5) @(negedge clk);
    chk("R10 alloc held", alloc_flat[3*W +: W], 60);
    chk("R10 alloc held a0", alloc_flat[0 +: W], 10);

    for (int t = 0; t < 40; t++) begin
      for (int i = 0; i < N; i++)
        dv[i] = ($urandom % 5 == 0) ? 0 : ($urandom % 4096);
      cv = $urandom % 16000;
      run_job("random", (t % 7) == 3);
    end
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (100000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule